// File: doc/BRIEF.md
# Pipelined 64-bit Integer Multiplier

This block is the multiply datapath of a 64-bit integer core. The core passes it two register operands and the low two bits of the multiply function code, along with a flag for the 32-bit word form. It returns a 64-bit result. The non-word forms return one of two halves of the 128-bit product. The first is the low half. The second is the high half, with the operands read as signed×signed, signed×unsigned or unsigned×unsigned. The word form multiplies the low 32 bits of each operand and sign-extends the 32-bit result to 64 bits.

Both operands are first reduced to magnitudes. Each magnitude is split into 32-bit halves, and four 32×32 partial products are formed. These are summed with an explicit carry out of the middle column. When exactly one operand is negative, the result is negated: the low half is two's-complemented, and the high half is complemented and incremented only when the low half is zero. The datapath has three register stages and accepts a new operation every cycle. A start pulse captures the operands, and a one-cycle done pulse comes out three rising edges later, together with the result.

Top module: `int_mul_unit`

## Requirements
- R1: While rst_ni is low, done_o is 0 and result_o is 0.
- R2: When start_i is sampled high at a rising edge, done_o is 1 for exactly one cycle after the third rising edge from that one, and the matching result_o appears in that same cycle. A start may be issued on every cycle, and the results come back in order. When no start was sampled three edges earlier, done_o is 0.
- R3: With word_i=0 and op_i=0, result_o is bits 63:0 of the product a_i×b_i.
- R4: With word_i=0 and op_i=1, result_o is bits 127:64 of the product of signed a_i and signed b_i.
- R5: With word_i=0 and op_i=2, result_o is bits 127:64 of the product of signed a_i and unsigned b_i.
- R6: With word_i=0 and op_i=3, result_o is bits 127:64 of the product of unsigned a_i and unsigned b_i.
- R7: A signed operand equal to 0x8000000000000000 is treated as the magnitude 2^63, so the R4 and R5 results for it are exact.
- R8: With word_i=1, result_o is the low 32 bits of a_i[31:0]×b_i[31:0], sign-extended from bit 31. In this form op_i and bits 63:32 of both operands have no effect.
- R9: result_o keeps its last value in every cycle where done_o is 0, whatever the inputs do while start_i is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Captures the operands, op_i and word_i |
| op_i | input | 2 | 0 low half, 1 high s×s, 2 high s×u, 3 high u×u |
| word_i | input | 1 | 32-bit word form with sign extension |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| done_o | output | 1 | Result valid, one-cycle pulse |
| result_o | output | 64 | Multiply result |

## Verification
Every result is due in the cycle after the third rising edge that follows the edge which sampled start_i. The bench raises start_i on a falling edge and lowers it on the next one. It then checks, on the intermediate falling edge, that done_o is still low, and it compares done_o and result_o on the falling edge that follows the third rising edge. For back-to-back issue, it sends three starts on consecutive cycles and checks one result per falling edge, in issue order. For R9, it changes the inputs with start_i low and confirms that done_o stays low and result_o does not move.

// File: rtl/imul_pkg.sv
package imul_pkg;
  typedef enum logic [1:0] {
    OP_LO    = 2'd0,
    OP_HI_SS = 2'd1,
    OP_HI_SU = 2'd2,
    OP_HI_UU = 2'd3
  } imul_op_e;
endpackage

// File: rtl/imul_prep.sv
module imul_prep import imul_pkg::*; #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [1:0]      op_i,
  input  logic            word_i,
  output logic [XLEN-1:0] mag_a_o,
  output logic [XLEN-1:0] mag_b_o,
  output logic            neg_o,
  output logic            take_hi_o
);
  localparam int unsigned HALF = XLEN / 2;

  logic sa, sb;

  always_comb begin
    sa = 1'b0;
    sb = 1'b0;
    if (word_i) begin
      // word form: low halves as unsigned, low half of product is exact
      mag_a_o   = {{(XLEN-HALF){1'b0}}, a_i[HALF-1:0]};
      mag_b_o   = {{(XLEN-HALF){1'b0}}, b_i[HALF-1:0]};
      neg_o     = 1'b0;
      take_hi_o = 1'b0;
    end else begin
      sa = ((op_i == OP_HI_SS) || (op_i == OP_HI_SU)) && a_i[XLEN-1];
      sb = (op_i == OP_HI_SS) && b_i[XLEN-1];
      // unsigned negate maps the most negative value to 2^(XLEN-1)
      mag_a_o   = sa ? (~a_i + 1'b1) : a_i;
      mag_b_o   = sb ? (~b_i + 1'b1) : b_i;
      neg_o     = sa ^ sb;
      take_hi_o = (op_i != OP_LO);
    end
  end
endmodule

// File: rtl/imul_partial.sv
module imul_partial #(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0]       mag_a_i,
  input  logic [XLEN-1:0]       mag_b_i,
  output logic [3:0][XLEN-1:0]  pp_o   // 3: hi*hi, 2: hi*lo, 1: lo*hi, 0: lo*lo
);
  localparam int unsigned HALF = XLEN / 2;

  for (genvar g = 0; g < 4; g++) begin : g_pp
    localparam bit AHI = (g / 2) == 1;
    localparam bit BHI = (g % 2) == 1;
    logic [HALF-1:0] x, y;
    assign x = AHI ? mag_a_i[XLEN-1:HALF] : mag_a_i[HALF-1:0];
    assign y = BHI ? mag_b_i[XLEN-1:HALF] : mag_b_i[HALF-1:0];
    assign pp_o[g] = {{(XLEN-HALF){1'b0}}, x} * {{(XLEN-HALF){1'b0}}, y};
  end
endmodule

// File: rtl/imul_combine.sv
module imul_combine #(
  parameter int unsigned XLEN = 64
) (
  input  logic [3:0][XLEN-1:0] pp_i,
  input  logic                 neg_i,
  input  logic                 take_hi_i,
  input  logic                 word_i,
  output logic [XLEN-1:0]      res_o
);
  localparam int unsigned HALF = XLEN / 2;

  logic [HALF+1:0] mid_sum;
  logic [XLEN-1:0] lo, hi, lo_s, hi_s;

  always_comb begin
    mid_sum = {2'b00, pp_i[2][HALF-1:0]} + {2'b00, pp_i[1][HALF-1:0]}
            + {2'b00, pp_i[0][XLEN-1:HALF]};
    lo = {mid_sum[HALF-1:0], pp_i[0][HALF-1:0]};
    hi = pp_i[3]
       + {{HALF{1'b0}}, pp_i[2][XLEN-1:HALF]}
       + {{HALF{1'b0}}, pp_i[1][XLEN-1:HALF]}
       + {{(XLEN-2){1'b0}}, mid_sum[HALF+1:HALF]};
    // 128-bit negate split in halves: borrow into high only when low is zero
    lo_s = neg_i ? (~lo + 1'b1) : lo;
    hi_s = neg_i ? (~hi + {{(XLEN-1){1'b0}}, (lo == '0)}) : hi;
    if (word_i)         res_o = {{(XLEN-HALF){lo[HALF-1]}}, lo[HALF-1:0]};
    else if (take_hi_i) res_o = hi_s;
    else                res_o = lo_s;
  end
endmodule

// File: rtl/int_mul_unit.sv
module int_mul_unit import imul_pkg::*; #(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic            word_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            done_o,
  output logic [XLEN-1:0] result_o
);
  localparam int unsigned HALF = XLEN / 2;

  // stage 1: captured operands
  logic            v1_q, word1_q;
  logic [1:0]      op1_q;
  logic [XLEN-1:0] a1_q, b1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0; word1_q <= 1'b0; op1_q <= '0; a1_q <= '0; b1_q <= '0;
    end else begin
      v1_q <= start_i;
      if (start_i) begin
        word1_q <= word_i; op1_q <= op_i; a1_q <= a_i; b1_q <= b_i;
      end
    end
  end

  logic [XLEN-1:0]      mag_a, mag_b;
  logic                 neg, take_hi;
  logic [3:0][XLEN-1:0] pp;

  imul_prep #(.XLEN(XLEN)) u_prep (
    .a_i(a1_q), .b_i(b1_q), .op_i(op1_q), .word_i(word1_q),
    .mag_a_o(mag_a), .mag_b_o(mag_b), .neg_o(neg), .take_hi_o(take_hi)
  );

  imul_partial #(.XLEN(XLEN)) u_partial (
    .mag_a_i(mag_a), .mag_b_i(mag_b), .pp_o(pp)
  );

  // stage 2: partial products
  logic                 v2_q, neg2_q, hi2_q, word2_q;
  logic [3:0][XLEN-1:0] pp2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q <= 1'b0; neg2_q <= 1'b0; hi2_q <= 1'b0; word2_q <= 1'b0; pp2_q <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        neg2_q <= neg; hi2_q <= take_hi; word2_q <= word1_q; pp2_q <= pp;
      end
    end
  end

  logic [XLEN-1:0] res;

  imul_combine #(.XLEN(XLEN)) u_combine (
    .pp_i(pp2_q), .neg_i(neg2_q), .take_hi_i(hi2_q), .word_i(word2_q), .res_o(res)
  );

  // stage 3: result
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0; result_o <= '0;
    end else begin
      done_o <= v2_q;
      if (v2_q) result_o <= res;
    end
  end

  // assertion support: edges seen since reset
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  // R2
  done_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (done_o == $past(start_i, 3)));

  // R3
  zero_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && done_o && $past(start_i && (a_i == '0 || b_i == '0), 3))
      |-> (result_o == '0));

  // R3
  lo_ident_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && done_o && $past(start_i && !word_i && op_i == OP_LO && b_i == 1, 3))
      |-> (result_o == $past(a_i, 3)));

  // R6
  hu_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && done_o && $past(start_i && !word_i && op_i == OP_HI_UU && b_i == 1, 3))
      |-> (result_o == '0));

  // R8
  word_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && done_o && $past(start_i && word_i, 3))
      |-> ((&result_o[XLEN-1:HALF-1]) || !(|result_o[XLEN-1:HALF-1])));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q != 2'd0 && !done_o) |-> $stable(result_o));
endmodule

// File: tb/tb_int_mul_unit.sv
module tb_int_mul_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        word_i = 1'b0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        done_o;
  logic [63:0] result_o;

  int total = 0;
  int bad = 0;

  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAXV = 64'h7fff_ffff_ffff_ffff;

  int_mul_unit #(.XLEN(64)) dut (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [63:0] ref_mul(logic [1:0] op, logic word,
                                          logic [63:0] a, logic [63:0] b);
    logic [127:0] ea, eb, p;
    logic [63:0]  pw;
    if (word) begin
      pw = {{32{a[31]}}, a[31:0]} * {{32{b[31]}}, b[31:0]};
      return {{32{pw[31]}}, pw[31:0]};
    end
    ea = (op == 2'd1 || op == 2'd2) ? {{64{a[63]}}, a} : {64'b0, a};
    eb = (op == 2'd1) ? {{64{b[63]}}, b} : {64'b0, b};
    p = ea * eb;
    return (op == 2'd0) ? p[63:0] : p[127:64];
  endfunction

  function automatic string req_of(logic [1:0] op, logic word,
                                   logic [63:0] a, logic [63:0] b);
    if (word) return "R8";
    if ((op == 2'd1 || op == 2'd2) && a == MINV) return "R7";
    if (op == 2'd1 && b == MINV) return "R7";
    case (op)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(logic [1:0] op, logic word, logic [63:0] a, logic [63:0] b);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; word_i = word; a_i = a; b_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    chk("R2", {63'b0, done_o}, 64'd0);
    @(negedge clk_i);
    chk("R2", {63'b0, done_o}, 64'd1);
    chk(req_of(op, word, a, b), result_o, ref_mul(op, word, a, b));
  endtask

  logic [63:0] corners [7];
  logic [63:0] ba [3], bb [3];
  logic [1:0]  bo [3];
  logic [63:0] held;

  initial begin
    void'($urandom(32'd1234));
    corners[0] = 64'd0; corners[1] = 64'd1; corners[2] = '1;
    corners[3] = MINV;  corners[4] = MAXV;
    corners[5] = 64'h0000_0000_8000_0000; corners[6] = 64'hffff_ffff_0000_0001;

    // R1
    repeat (3) @(negedge clk_i);
    chk("R1", {63'b0, done_o}, 64'd0);
    chk("R1", result_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", {63'b0, done_o}, 64'd0);

    for (int op = 0; op < 4; op++)
      for (int i = 0; i < 7; i++)
        for (int j = 0; j < 7; j++)
          run_one(op[1:0], 1'b0, corners[i], corners[j]);

    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++)
        run_one(2'($urandom()), 1'b1, corners[i], corners[j]);

    for (int n = 0; n < 400; n++) begin
      logic [63:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if ($urandom() % 8 == 0) ra = corners[$urandom() % 7];
      if ($urandom() % 8 == 0) rb = corners[$urandom() % 7];
      run_one(2'($urandom()), ($urandom() % 4 == 0), ra, rb);
    end

    // R8: op and upper bits do not change the word result
    run_one(2'd3, 1'b1, 64'hdead_beef_ffff_fffe, 64'h1234_5678_0000_0003);
    chk("R8", result_o, 64'hffff_ffff_ffff_fffa);

    // R9: input changes without start leave result and done alone
    held = result_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      a_i = {$urandom(), $urandom()}; b_i = {$urandom(), $urandom()};
      op_i = 2'($urandom()); word_i = ~word_i;
      chk("R9", {63'b0, done_o}, 64'd0);
      chk("R9", result_o, held);
    end

    // R2: back-to-back issue, results in order one per cycle
    for (int k = 0; k < 3; k++) begin
      ba[k] = {$urandom(), $urandom()};
      bb[k] = {$urandom(), $urandom()};
      bo[k] = 2'(k + 1);
    end
    @(negedge clk_i);
    for (int k = 0; k < 3; k++) begin
      start_i = 1'b1; word_i = 1'b0; op_i = bo[k]; a_i = ba[k]; b_i = bb[k];
      @(negedge clk_i);
    end
    start_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R2", {63'b0, done_o}, 64'd1);
      chk("R2", result_o, ref_mul(bo[k], 1'b0, ba[k], bb[k]));
      @(negedge clk_i);
    end
    chk("R2", {63'b0, done_o}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule